// File: doc/BRIEF.md
# E1 Far-End Block Error Counter

This block counts the remote-end block error reports on an E1 receive path that uses CRC-4 multiframing. Upstream framing logic hands it two things. The first is the first bit of timeslot 0, qualified by a one-cycle strobe. The second is the index of the current frame inside the 16-frame multiframe, along with flags that tell whether frame alignment, CRC-4 multiframe alignment and CAS multiframe alignment are held.

Only the report bit positions are sampled, which are frames 13 and 15 of the multiframe. A received 0 in one of those positions is one error. Counting stops whenever frame alignment or CRC-4 alignment is lost. Loss of CAS multiframe alignment has no effect on counting.

The host takes periodic samples, typically one per second, by pulsing a latch/clear input. That pulse copies the running count into a 16-bit snapshot and restarts the running count. The host then reads the snapshot as two bytes over a small synchronous read port.

Top module: `e1_febe_counter`

## Requirements
- R1: When `mode_e1` is 0 (T1 selected), the running count never changes except through `latch_clr`.
- R2: Only strobes whose 4-bit `frame_idx` equals 13 or 15 may change the count. Strobes with any other index (0..12, 14) leave the count unchanged.
- R3: A qualified strobe with `ebit_in` = 0 adds exactly one to the count. A qualified strobe with `ebit_in` = 1 adds nothing.
- R4: A read of address 0x48 returns bits 15..8 of the snapshot, and a read of address 0x49 returns bits 7..0. `rd_data` is valid on the cycle after the one in which `rd_en` is high.
- R5: After reset, the running count, the snapshot and `rd_data` are all zero.
- R6: No counting takes place while `fas_sync_ok` is 0 or while `crc_sync_ok` is 0.
- R7: The value of `cas_sync_ok` has no effect. Counting proceeds whenever E1 mode, frame sync and CRC-4 sync all hold.
- R8: The count holds at least 1000 errors in one interval exactly, with no wrap. For example, 1000 errors are read back as 0x03 and 0xE8.
- R9: A `latch_clr` pulse copies the running count, taken before any increment in that same cycle, into the snapshot. It restarts the running count at zero, and an error arriving in that same cycle counts as 1 in the new interval.
- R10: Each strobe adds at most one. An E-bit of 0 with `bit_vld` low does not count.
- R11: A read of any address other than 0x48 or 0x49 returns 0, and `rd_data` is 0 on the cycle after a cycle with `rd_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_e1 | input | 1 | 1 = E1 operation, 0 = T1 (counter frozen) |
| bit_vld | input | 1 | One-cycle strobe qualifying `ebit_in` |
| ebit_in | input | 1 | First bit of timeslot 0 of the current frame |
| frame_idx | input | 4 | Frame number within the CRC-4 multiframe (0..15) |
| fas_sync_ok | input | 1 | Frame alignment held |
| crc_sync_ok | input | 1 | CRC-4 multiframe alignment held |
| cas_sync_ok | input | 1 | CAS multiframe alignment held (ignored) |
| latch_clr | input | 1 | Snapshot running count and restart it |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |

## Verification
Several rules are checked by assertions on every cycle:
- the count moves by at most one per cycle;
- the count is frozen in T1 mode, on frames outside the report positions, and while either sync flag is down;
- the count never wraps;
- a latch pulse moves the old count into the snapshot;
- unmapped reads and idle reads return zero.

Other behaviour can only be shown by the bench's scenarios. These are that zeros count while ones do not, that the CAS flag is truly irrelevant across every combination of the other inputs, that an error arriving together with a latch lands in the new interval, and that the byte order is correct at both register addresses.

// File: rtl/febe_pkg.sv
package febe_pkg;
  localparam int FRAME_W = 4;
  localparam int BYTE_W  = 8;

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [63:0] v, input int lane);
    return v[lane*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/febe_qualifier.sv
module febe_qualifier
  import febe_pkg::*;
#(
  parameter int EFRAME_A = 13,
  parameter int EFRAME_B = 15
) (
  input  logic               mode_e1,
  input  logic               bit_vld,
  input  logic               ebit_in,
  input  logic [FRAME_W-1:0] frame_idx,
  input  logic               fas_sync_ok,
  input  logic               crc_sync_ok,
  input  logic               cas_sync_ok,
  output logic               err_inc
);
  logic in_slot;
  logic aligned;
  logic cas_unused;

  assign in_slot    = (frame_idx == FRAME_W'(EFRAME_A)) || (frame_idx == FRAME_W'(EFRAME_B));
  assign aligned    = fas_sync_ok && crc_sync_ok;
  assign cas_unused = cas_sync_ok;

  always_comb begin
    err_inc = 1'b0;
    if (mode_e1 && bit_vld && in_slot && aligned)
      err_inc = ~ebit_in;
  end
endmodule

// File: rtl/febe_accum.sv
module febe_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_inc,
  input  logic             latch_clr,
  output logic [CNT_W-1:0] live_cnt,
  output logic [CNT_W-1:0] snap_cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      live_cnt <= '0;
      snap_cnt <= '0;
    end else if (latch_clr) begin
      snap_cnt <= live_cnt;
      live_cnt <= err_inc ? ONE : '0;
    end else if (err_inc) begin
      live_cnt <= live_cnt + ONE;
    end
  end

  // R8: running count never wraps
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !(live_cnt == TOP && err_inc && !latch_clr));

  // R9: latch pulse moves old count to snapshot and restarts the live count
  a_r9_latch_moves: assert property (@(posedge clk) disable iff (rst)
    latch_clr |=> (snap_cnt == $past(live_cnt)) && (live_cnt <= ONE));
endmodule

// File: rtl/febe_regbus.sv
module febe_regbus
  import febe_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  snap_cnt,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int NLANE = CNT_W / BYTE_W;

  logic [BYTE_W-1:0] lane_val [NLANE];
  logic [NLANE-1:0]  lane_hit;
  logic [BYTE_W-1:0] rd_mux;

  // most significant lane sits at the base address
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    assign lane_hit[k] = (rd_addr == ADDR_W'(BASE_ADDR + (NLANE - 1 - k)));
    assign lane_val[k] = snap_cnt[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NLANE; k++)
      if (lane_hit[k]) rd_mux = rd_mux | lane_val[k];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_en ? rd_mux : '0;
  end

  // R11: unmapped or idle reads give zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || (rd_addr < ADDR_W'(BASE_ADDR)) || (rd_addr >= ADDR_W'(BASE_ADDR + NLANE)))
      |=> rd_data == '0);

  // R4: at most one lane decoded per address
  a_r4_one_lane: assert property (@(posedge clk) disable iff (rst) $onehot0(lane_hit));
endmodule

// File: rtl/e1_febe_counter.sv
module e1_febe_counter
  import febe_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h48,
  parameter int EFRAME_A  = 13,
  parameter int EFRAME_B  = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_e1,
  input  logic               bit_vld,
  input  logic               ebit_in,
  input  logic [FRAME_W-1:0] frame_idx,
  input  logic               fas_sync_ok,
  input  logic               crc_sync_ok,
  input  logic               cas_sync_ok,
  input  logic               latch_clr,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0]  rd_data
);
  logic             err_inc;
  logic [CNT_W-1:0] live_cnt;
  logic [CNT_W-1:0] snap_cnt;

  febe_qualifier #(.EFRAME_A(EFRAME_A), .EFRAME_B(EFRAME_B)) u_qual (
    .mode_e1(mode_e1), .bit_vld(bit_vld), .ebit_in(ebit_in), .frame_idx(frame_idx),
    .fas_sync_ok(fas_sync_ok), .crc_sync_ok(crc_sync_ok), .cas_sync_ok(cas_sync_ok),
    .err_inc(err_inc)
  );

  febe_accum #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .err_inc(err_inc), .latch_clr(latch_clr),
    .live_cnt(live_cnt), .snap_cnt(snap_cnt)
  );

  febe_regbus #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_bus (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .snap_cnt(snap_cnt), .rd_data(rd_data)
  );

  // R1: T1 mode freezes the count
  a_r1_t1_frozen: assert property (@(posedge clk) disable iff (rst)
    (!mode_e1 && !latch_clr) |=> $stable(live_cnt));

  // R2: non-report frames never count
  a_r2_slot_only: assert property (@(posedge clk) disable iff (rst)
    (frame_idx != FRAME_W'(EFRAME_A) && frame_idx != FRAME_W'(EFRAME_B) && !latch_clr)
      |=> $stable(live_cnt));

  // R6: sync loss suspends counting
  a_r6_sync_gate: assert property (@(posedge clk) disable iff (rst)
    ((!fas_sync_ok || !crc_sync_ok) && !latch_clr) |=> $stable(live_cnt));

  // R10: at most one per strobe, none without a strobe
  a_r10_step: assert property (@(posedge clk) disable iff (rst)
    !latch_clr |=> (live_cnt == $past(live_cnt)) ||
                   (live_cnt == $past(live_cnt) + CNT_W'(1) && $past(bit_vld)));
endmodule

// File: tb/e1_febe_counter_tb.sv
module e1_febe_counter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_e1 = 1'b1, bit_vld = 1'b0, ebit_in = 1'b1;
  logic [3:0] frame_idx = '0;
  logic       fas_sync_ok = 1'b1, crc_sync_ok = 1'b1, cas_sync_ok = 1'b1;
  logic       latch_clr = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int exp_live = 0, exp_snap = 0;

  always #10 clk = ~clk;

  e1_febe_counter u_dut (
    .clk(clk), .rst(rst), .mode_e1(mode_e1), .bit_vld(bit_vld), .ebit_in(ebit_in),
    .frame_idx(frame_idx), .fas_sync_ok(fas_sync_ok), .crc_sync_ok(crc_sync_ok),
    .cas_sync_ok(cas_sync_ok), .latch_clr(latch_clr), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic strobe(input logic m, input logic f, input logic c, input logic s,
                        input int fr, input logic eb, input logic v);
    @(negedge clk);
    mode_e1 = m; fas_sync_ok = f; crc_sync_ok = c; cas_sync_ok = s;
    frame_idx = 4'(fr); ebit_in = eb; bit_vld = v;
    if (m && f && c && v && !eb && (fr == 13 || fr == 15)) exp_live++;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic latch(input logic with_err);
    @(negedge clk);
    latch_clr = 1'b1;
    mode_e1 = 1; fas_sync_ok = 1; crc_sync_ok = 1;
    frame_idx = 4'd13; ebit_in = 1'b0; bit_vld = with_err;
    exp_snap = exp_live;
    exp_live = with_err ? 1 : 0;
    @(negedge clk);
    latch_clr = 1'b0; bit_vld = 1'b0; ebit_in = 1'b1;
  endtask

  task automatic rd(input int a, input logic en, output int v);
    @(negedge clk);
    rd_en = en; rd_addr = 8'(a);
    @(negedge clk);
    v = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic read_snap(input string req);
    int hi, lo;
    rd('h48, 1, hi);
    rd('h49, 1, lo);
    check(req, (hi << 8) | lo, exp_snap & 16'hFFFF);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R5 reset state
    check("R5 rd_data", rd_data, 0);
    read_snap("R5 snapshot");
    latch(0);
    read_snap("R5 live count");

    // sweep mode x fas x crc x cas, each over all frames and both bit values
    for (int g = 0; g < 16; g++) begin
      for (int fr = 0; fr < 16; fr++)
        for (int eb = 0; eb < 2; eb++)
          strobe(g[3], g[2], g[1], g[0], fr, eb[0], 1'b1);
      latch(0);
      // R1 R2 R3 R6 R7: expect 2 when E1 and both syncs held, else 0
      read_snap($sformatf("R1/R2/R3/R6/R7 group %0d", g));
    end

    // R3: ones never count at frame 13/15
    for (int k = 0; k < 5; k++) strobe(1, 1, 1, 0, 15, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) strobe(1, 1, 1, 0, 13, 1'b0, 1'b1);
    latch(0);
    read_snap("R3 zeros only");

    // R10: E-bit 0 without strobe
    for (int k = 0; k < 4; k++) strobe(1, 1, 1, 1, 13, 1'b0, 1'b0);
    latch(0);
    read_snap("R10 no strobe");
    // R10: strobe held over several cycles of one report each
    @(negedge clk);
    frame_idx = 4'd15; ebit_in = 1'b0; bit_vld = 1'b1;
    repeat (3) @(negedge clk);
    bit_vld = 1'b0; exp_live = 3;
    latch(0);
    read_snap("R10 one per strobe cycle");

    // R9: error in the same cycle as latch goes into new interval
    strobe(1, 1, 1, 1, 13, 1'b0, 1'b1);
    latch(1);
    read_snap("R9 snapshot old");
    latch(0);
    read_snap("R9 new interval");

    // R8: 1000 errors, no wrap
    for (int k = 0; k < 1000; k++) strobe(1, 1, 1, k[0], (k % 2) ? 13 : 15, 1'b0, 1'b1);
    latch(0);
    rd('h48, 1, v); check("R8 high byte", v, 'h03);
    rd('h49, 1, v); check("R8 low byte", v, 'hE8);
    read_snap("R4 byte order");

    // R11: all other addresses zero, rd_en low gives zero
    for (int a = 0; a < 256; a++) begin
      rd(a, 1, v);
      if (a == 'h48)      check("R4 addr 0x48", v, 'h03);
      else if (a == 'h49) check("R4 addr 0x49", v, 'hE8);
      else                check($sformatf("R11 addr %0h", a), v, 0);
    end
    rd('h49, 0, v);
    check("R11 rd_en low", v, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule